// File: doc/BRIEF.md
# Multi-Port GPIO Data Register Bank

This block holds the output data latches for a row of byte-wide general-purpose I/O ports and connects them to a simple register bus. Every port appears at its own byte address inside one contiguous window. A per-bit direction input decides what each bit does. For an output bit, the latch drives the pad and is what a read returns. For an input bit, a read returns the level sampled on the pin after a two-stage synchronizer.

Several pins behave differently from the rest. Two pins of one port are open drain: they pull low for a 0 and release the pad for a 1. One bit of another port accepts no writes and always reads as the pin. While the external-bus mode input is high, bits marked in a per-port lock mask keep their latch contents through a write.

A contiguous group of ports is gated by a single enable. While the enable is low, the latches of that group are held at zero, the group's pads are released, its reads return zero and writes to it are lost.

Top module: `gpio_bank`

## Requirements
- R1: While `rst` is high at a clock edge, all latches clear to 8'h00. `bus_rdata`, `pad_out` and `pad_oe` are all zero after that edge.
- R2: Port p (0..7) sits at bus address 2+p. A write there with `bus_wr` high updates that port's latch at the clock edge. Port p uses bits [8p+7:8p] of every wide port vector.
- R3: A direction bit of 1 marks an output. For such a bit, a read returns the latch. From the edge after the latch changes, the pad drives `pad_out` equal to the latch with `pad_oe` high.
- R4: A direction bit of 0 marks an input. For such a bit, `pad_oe` is low, and a read returns the `pin_in` level present at least two clock edges before the read strobe.
- R5: Port 3 bits 0 and 1 are open drain. A latch value of 1 gives `pad_oe` low. A latch value of 0 on an output bit gives `pad_oe` high with `pad_out` low. `pad_out` is never high on these bits.
- R6: Port 4 bit 5 is read-only. Writes leave its latch unchanged, a read always returns its pin level, and its `pad_oe` stays low.
- R7: While `ext_bus_mode` is high, a write leaves unchanged every latch bit whose `bus_lock_mask` bit is 1. While `ext_bus_mode` is low, the mask has no effect.
- R8: Ports 5, 6 and 7 form the gated group. While `grp_enable` is low, their latches are held at 8'h00, their `pad_oe` and `pad_out` bits are low, their reads return 8'h00 and writes to them are ignored. Their latches are still 8'h00 after the group is re-enabled.
- R9: A read at an address outside 2..9 returns 8'h00. A write there changes no latch.
- R10: `bus_rdata` is registered. It takes the selected value at the edge where `bus_rd` is high and holds its value at edges where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| port_dir | input | NUM_PORTS*8 (64) | Per-bit direction, 1 = output |
| pin_in | input | NUM_PORTS*8 (64) | Asynchronous pin levels |
| ext_bus_mode | input | 1 | External-bus mode active |
| bus_lock_mask | input | NUM_PORTS*8 (64) | Bits whose writes are blocked while the external-bus mode is active |
| grp_enable | input | 1 | Enable for the gated port group |
| pad_out | output | NUM_PORTS*8 (64) | Registered pad output level |
| pad_oe | output | NUM_PORTS*8 (64) | Registered pad output enable |

## Verification
The hardest case to reach is a write that meets more than one exception at once. Examples are a locked write to a gated port just as the group is switched off, or a write to the port that holds both a locked bit and the read-only bit. Directed cases cover each exception on its own. A seeded random phase then mixes writes to every address, including unmapped ones, with changes to direction, pins, lock mask, bus mode and group enable. This makes these combinations arise in ordinary sequences. After every step, each read and every pad bit is compared with a bench model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // True when port index idx falls inside [first, first+count).
  function automatic logic in_span(input int idx, input int first, input int count);
    return (idx >= first) && (idx < first + count);
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_a;
  logic [WIDTH-1:0] stage_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_a <= '0;
      stage_b <= '0;
    end else begin
      stage_a <= async_in;
      stage_b <= stage_a;
    end
  end

  assign sync_out = stage_b;
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
  import gpio_bank_pkg::*;
#(
  parameter bit    GATED    = 1'b0,
  parameter byte_t OD_BITS  = '0,
  parameter byte_t RO_BITS  = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_hit,
  input  byte_t wdata,
  input  byte_t dir,
  input  byte_t pin_sync,
  input  byte_t lock_bits,
  input  logic  grp_on,
  output byte_t latch_q,
  output byte_t rd_val,
  output byte_t pad_out_q,
  output byte_t pad_oe_q
);
  logic  off;
  byte_t keep;
  byte_t drive_dir;

  assign off       = GATED && !grp_on;
  assign keep      = lock_bits | RO_BITS;
  assign drive_dir = dir & ~RO_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (off) begin
      latch_q <= '0;
    end else if (wr_hit) begin
      latch_q <= (latch_q & keep) | (wdata & ~keep);
    end
  end

  always_comb begin
    if (off) begin
      rd_val = '0;
    end else begin
      rd_val = (drive_dir & latch_q) | (~drive_dir & pin_sync);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || off) begin
      pad_out_q <= '0;
      pad_oe_q  <= '0;
    end else begin
      pad_out_q <= latch_q & ~OD_BITS;
      pad_oe_q  <= drive_dir & ~(OD_BITS & latch_q);
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int    NUM_PORTS  = 8,
  parameter int    ADDR_W     = 4,
  parameter int    BASE_ADDR  = 2,
  parameter int    GATE_FIRST = 5,
  parameter int    GATE_COUNT = 3,
  parameter int    OD_PORT    = 3,
  parameter byte_t OD_MASK    = 8'h03,
  parameter int    RO_PORT    = 4,
  parameter byte_t RO_MASK    = 8'h20
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [7:0]                      bus_wdata,
  output logic [7:0]                      bus_rdata,
  input  logic [NUM_PORTS*BYTE_W-1:0]     port_dir,
  input  logic [NUM_PORTS*BYTE_W-1:0]     pin_in,
  input  logic                            ext_bus_mode,
  input  logic [NUM_PORTS*BYTE_W-1:0]     bus_lock_mask,
  input  logic                            grp_enable,
  output logic [NUM_PORTS*BYTE_W-1:0]     pad_out,
  output logic [NUM_PORTS*BYTE_W-1:0]     pad_oe
);
  localparam int PIN_W = NUM_PORTS * BYTE_W;

  logic [PIN_W-1:0]     pin_sync;
  logic [PIN_W-1:0]     latch_flat;
  logic [PIN_W-1:0]     rd_flat;
  logic [NUM_PORTS-1:0] sel;
  byte_t                rd_next;

  gpio_pin_sync #(.WIDTH(PIN_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam bit    IS_GATED = in_span(p, GATE_FIRST, GATE_COUNT);
    localparam byte_t OD_P     = (p == OD_PORT) ? OD_MASK : byte_t'(0);
    localparam byte_t RO_P     = (p == RO_PORT) ? RO_MASK : byte_t'(0);

    assign sel[p] = (bus_addr == ADDR_W'(BASE_ADDR + p));

    gpio_port_slice #(
      .GATED   (IS_GATED),
      .OD_BITS (OD_P),
      .RO_BITS (RO_P)
    ) u_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (bus_wr && sel[p]),
      .wdata     (bus_wdata),
      .dir       (port_dir[p*BYTE_W +: BYTE_W]),
      .pin_sync  (pin_sync[p*BYTE_W +: BYTE_W]),
      .lock_bits (ext_bus_mode ? bus_lock_mask[p*BYTE_W +: BYTE_W] : byte_t'(0)),
      .grp_on    (grp_enable),
      .latch_q   (latch_flat[p*BYTE_W +: BYTE_W]),
      .rd_val    (rd_flat[p*BYTE_W +: BYTE_W]),
      .pad_out_q (pad_out[p*BYTE_W +: BYTE_W]),
      .pad_oe_q  (pad_oe[p*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel[p]) rd_next = rd_flat[p*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int    NUM_PORTS  = 8,
  parameter int    ADDR_W     = 4,
  parameter int    BASE_ADDR  = 2,
  parameter int    GATE_FIRST = 5,
  parameter int    GATE_COUNT = 3,
  parameter int    OD_PORT    = 3,
  parameter byte_t OD_MASK    = 8'h03,
  parameter int    RO_PORT    = 4,
  parameter byte_t RO_MASK    = 8'h20
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [7:0]                  bus_rdata,
  input logic                        ext_bus_mode,
  input logic [NUM_PORTS*BYTE_W-1:0] bus_lock_mask,
  input logic                        grp_enable,
  input logic [NUM_PORTS*BYTE_W-1:0] pad_out,
  input logic [NUM_PORTS*BYTE_W-1:0] pad_oe,
  input logic [NUM_PORTS*BYTE_W-1:0] latch_flat
);
  localparam int PIN_W = NUM_PORTS * BYTE_W;

  function automatic logic [PIN_W-1:0] group_bits();
    logic [PIN_W-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (in_span(p, GATE_FIRST, GATE_COUNT)) m[p*BYTE_W +: BYTE_W] = '1;
    return m;
  endfunction

  localparam logic [PIN_W-1:0] GRP_BITS = group_bits();

  logic unmapped;
  assign unmapped = (int'(bus_addr) < BASE_ADDR) || (int'(bus_addr) >= BASE_ADDR + NUM_PORTS);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && latch_flat == '0 && pad_oe == '0 && pad_out == '0));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == '0));

  assert_unmapped_write_noop_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && unmapped && grp_enable) |=> $stable(latch_flat));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (rst)
    (pad_out[OD_PORT*BYTE_W +: BYTE_W] & OD_MASK) == '0);

  assert_ro_latch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ((latch_flat[RO_PORT*BYTE_W +: BYTE_W] | pad_oe[RO_PORT*BYTE_W +: BYTE_W]) & RO_MASK) == '0);

  assert_group_off_R8: assert property (@(posedge clk) disable iff (rst)
    !grp_enable |=> ((latch_flat & GRP_BITS) == '0 && (pad_oe & GRP_BITS) == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lock
    localparam bit IS_GATED = in_span(p, GATE_FIRST, GATE_COUNT);
    assert_lock_keeps_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && int'(bus_addr) == BASE_ADDR + p && ext_bus_mode && (!IS_GATED || grp_enable))
      |=> (((latch_flat[p*BYTE_W +: BYTE_W] ^ $past(latch_flat[p*BYTE_W +: BYTE_W]))
            & $past(bus_lock_mask[p*BYTE_W +: BYTE_W])) == '0));
  end
endmodule

bind gpio_bank gpio_bank_checker #(
  .NUM_PORTS  (NUM_PORTS),
  .ADDR_W     (ADDR_W),
  .BASE_ADDR  (BASE_ADDR),
  .GATE_FIRST (GATE_FIRST),
  .GATE_COUNT (GATE_COUNT),
  .OD_PORT    (OD_PORT),
  .OD_MASK    (OD_MASK),
  .RO_PORT    (RO_PORT),
  .RO_MASK    (RO_MASK)
) u_checker (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .ext_bus_mode  (ext_bus_mode),
  .bus_lock_mask (bus_lock_mask),
  .grp_enable    (grp_enable),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .latch_flat    (latch_flat)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [63:0] port_dir = '0;
  logic [63:0] pin_in = '0;
  logic        ext_bus_mode = 1'b0;
  logic [63:0] bus_lock_mask = '0;
  logic        grp_enable = 1'b1;
  logic [63:0] pad_out;
  logic [63:0] pad_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [NP];

  always #2 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_dir(port_dir), .pin_in(pin_in),
    .ext_bus_mode(ext_bus_mode), .bus_lock_mask(bus_lock_mask), .grp_enable(grp_enable),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic bit gated(int p); return p >= 5 && p <= 7; endfunction
  function automatic logic [7:0] od_of(int p); return (p == 3) ? 8'h03 : 8'h00; endfunction
  function automatic logic [7:0] ro_of(int p); return (p == 4) ? 8'h20 : 8'h00; endfunction
  function automatic bit off(int p); return gated(p) && !grp_enable; endfunction

  function automatic logic [7:0] exp_read(int a);
    int p;
    logic [7:0] d;
    if (a < 2 || a > 9) return 8'h00;
    p = a - 2;
    if (off(p)) return 8'h00;
    d = port_dir[p*8 +: 8] & ~ro_of(p);
    return (d & mdl[p]) | (~d & pin_in[p*8 +: 8]);
  endfunction

  function automatic logic [7:0] exp_oe(int p);
    if (off(p)) return 8'h00;
    return port_dir[p*8 +: 8] & ~ro_of(p) & ~(od_of(p) & mdl[p]);
  endfunction

  function automatic logic [7:0] exp_out(int p);
    if (off(p)) return 8'h00;
    return mdl[p] & ~od_of(p);
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_write(int a, logic [7:0] d);
    int p;
    logic [7:0] keep;
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 2 && a <= 9) begin
      p = a - 2;
      if (!off(p)) begin
        keep = (ext_bus_mode ? bus_lock_mask[p*8 +: 8] : 8'h00) | ro_of(p);
        mdl[p] = (mdl[p] & keep) | (d & ~keep);
      end
    end
  endtask

  task automatic do_read(int a, string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = 4'(a); bus_rd = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check8(tag, bus_rdata, e);
  endtask

  task automatic check_pads(string tag);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check8({tag, " oe"}, pad_oe[p*8 +: 8], exp_oe(p));
      check8({tag, " out"}, pad_out[p*8 +: 8], exp_out(p));
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) if (off(p)) mdl[p] = 8'h00;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int unused_seed;
    logic [7:0] held;
    unused_seed = $urandom(32'd24601);
    for (int p = 0; p < NP; p++) mdl[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check8("R1 rdata", bus_rdata, 8'h00);
    check8("R1 oe", pad_oe[7:0], 8'h00);
    check8("R1 out", pad_out[7:0], 8'h00);

    // R2 / R3: all outputs, write and read back
    port_dir = '1;
    settle();
    do_write(2, 8'hA5);
    do_read(2, "R2 R3 readback");
    check_pads("R3 pads");

    // R4: inputs and mixed direction
    port_dir[15:8] = 8'h00; pin_in[15:8] = 8'h3C;
    port_dir[23:16] = 8'hF0; pin_in[23:16] = 8'h5A;
    settle();
    do_write(4, 8'hC3);
    do_read(3, "R4 input");
    do_read(4, "R4 mixed");
    check_pads("R4 pads");

    // R5: open drain
    do_write(5, 8'h01);
    check_pads("R5 od");
    do_write(5, 8'h02);
    check_pads("R5 od swap");

    // R6: read-only bit
    pin_in[39:32] = 8'h20;
    settle();
    do_write(6, 8'h00);
    do_read(6, "R6 ro pin high");
    pin_in[39:32] = 8'h00;
    settle();
    do_write(6, 8'hFF);
    do_read(6, "R6 ro pin low");
    check_pads("R6 pads");

    // R7: lock under external-bus mode
    ext_bus_mode = 1'b1; bus_lock_mask[7:0] = 8'h0F;
    do_write(2, 8'h00);
    do_read(2, "R7 locked");
    ext_bus_mode = 1'b0;
    do_write(2, 8'h00);
    do_read(2, "R7 unlocked");

    // R8: gated group
    do_write(8, 8'h77);
    do_read(8, "R8 enabled");
    grp_enable = 1'b0;
    settle();
    do_read(8, "R8 disabled read");
    check_pads("R8 disabled pads");
    do_write(8, 8'h11);
    grp_enable = 1'b1;
    settle();
    do_read(8, "R8 reenabled");

    // R9: unmapped addresses
    do_write(0, 8'hFF); do_write(1, 8'hFF); do_write(12, 8'hFF);
    do_read(0, "R9 unmapped 0");
    do_read(15, "R9 unmapped 15");
    for (int a = 2; a <= 9; a++) do_read(a, "R9 mapped unchanged");

    // R10: hold without read strobe
    do_write(3, 8'h99);
    do_read(3, "R10 setup");
    held = exp_read(3);
    pin_in = ~pin_in;
    do_write(3, 8'h11);
    repeat (4) @(negedge clk);
    check8("R10 hold", bus_rdata, held);
    settle();

    // Constrained random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) begin
        do_write(int'($urandom % 16), 8'($urandom));
        check_pads("R2 R3 R5 R7 random pads");
      end else if (op < 7) begin
        do_read(int'($urandom % 16), "R3 R4 R6 R9 random read");
      end else if (op == 7) begin
        port_dir = {$urandom, $urandom};
        pin_in = {$urandom, $urandom};
        settle();
        check_pads("R4 random dir");
      end else if (op == 8) begin
        ext_bus_mode = 1'($urandom);
        bus_lock_mask = {$urandom, $urandom};
      end else begin
        grp_enable = ($urandom % 4) != 0;
        settle();
        check_pads("R8 random group");
      end
    end

    summary();
    $finish;
  end
endmodule